// File: doc/BRIEF.md
# Dual-Bank Clock Divider Configuration with Glitchless Handover

This block holds two full divider configurations for one generated clock and picks which of them drives the output. Each configuration has its own source choice, integer pre-divider and fractional M/N stage. A single select bit chooses the live configuration. Software rewrites the idle one while the live one keeps running, then flips the select bit. The handover completes only after the new configuration's source has shown activity. The output is a clock-enable pulse stream in the block's own clock domain. Each source is delivered as a one-cycle `src_tick` strobe per source edge.

While the output is enabled, the live configuration cannot be touched: a write aimed at it is dropped and a sticky error flag records the attempt. While the output is disabled, either configuration may be written, and the select bit takes effect at once. The control word always reads back the configuration that is actually live, so software can poll until a requested switch has landed.

Top module: `dual_bank_clkcfg`

## Requirements
- R1: After reset the output is disabled, bank 0 is live, no switch is pending, the error flag is clear, `out_tick` is 0, and both bank words read 0 (source 0, divide by 1, fractional stage off).
- R2: `out_tick` is high in the cycle after a cycle in which the output is enabled and the live bank emits a tick, unless that cycle is a switch cycle (R9). It is always low in the cycle after a cycle in which the output is disabled.
- R3: A bank word holds its source index in bits [1:0] and a pre-divide field in bits [5:2] equal to the divide value minus 1. The bank emits one pre-divided tick on every (field+1)-th strobe of `src_tick[source]`.
- R4: When bank word bit 22 is 1 and N (bits [21:14]) is non-zero, the fractional stage passes M (bits [13:6]) of every N pre-divided ticks, with M ≤ N. An accumulator adds M on each pre-divided tick and emits when the sum reaches N, keeping sum−N. Otherwise every pre-divided tick is emitted.
- R5: Bank words sit at address 1 (bank 0) and address 2 (bank 1). A write is refused when the output is enabled and the target is the live bank, or when a switch is pending. A refused write leaves the word unchanged and sets the error flag. An accepted write stores the word and restarts that bank's pre-divide count and accumulator from zero.
- R6: The error flag stays set until a write to the control word (address 0) has bit 3 set to 1.
- R7: Reading address 0 returns the live bank in bit 0, the enable in bit 1, pending in bit 2 and the error flag in bit 3. Bit 0 keeps showing the old bank while a switch is pending.
- R8: A control write that keeps enable (bit 1) at 1 while the output is already enabled, with select (bit 0) different from the live bank, makes a switch pending. The switch completes at the edge ending the second cycle with a strobe on the target bank's selected source. A control write that selects the live bank cancels a pending switch.
- R9: The cycle in which a pending switch completes emits no output tick. Before that cycle the old bank keeps driving the output.
- R10: A control write made while the output is disabled, or one that clears enable, makes its select value live at once with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One strobe per edge of each candidate source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | DW | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | DW | Read data for `bus_raddr` (combinational) |
| out_tick | output | 1 | Registered output clock-enable pulse |

## Verification
Every cycle, the assertions check four things: the output stays quiet after a disabled cycle, and an enabled bank change happens only through a pending switch and never emits a pulse in the switch cycle. They also check that the live bank word never moves while enabled and that the error flag never clears without an explicit clear. Other behaviour needs the bench's scenarios and its cycle-exact model: the exact pulse cadence for each pre-divide and M/N setting, the stall of a handover whose target source is silent, the two-strobe handover timing, and cancellation.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_BANK0 = 2'd1,
      RA_BANK1 = 2'd2,
      RA_NONE  = 2'd3
   } reg_addr_e;

   localparam int CB_ACTIVE  = 0;
   localparam int CB_ENABLE  = 1;
   localparam int CB_PENDING = 2;
   localparam int CB_ERROR   = 3;
   localparam int NBANK      = 2;
endpackage

// File: rtl/rcfg_divider.sv
module rcfg_divider #(
   parameter int NSRC   = 4,
   parameter int SRCW   = 2,
   parameter int PDW    = 4,
   parameter int MNW    = 8,
   parameter bit HAS_MN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [NSRC-1:0] src_tick,
   input  logic [SRCW-1:0] src_sel,
   input  logic [PDW-1:0]  pdiv,
   input  logic [MNW-1:0]  m_val,
   input  logic [MNW-1:0]  n_val,
   input  logic            mn_on,
   output logic            tick
);
   localparam int ACCW = MNW + 1;

   logic           sel_tick;
   logic           pre_tick;
   logic [PDW-1:0] pcnt_q;

   assign sel_tick = src_tick[src_sel];
   assign pre_tick = sel_tick && (pcnt_q == pdiv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pcnt_q <= '0;
      else if (clr)       pcnt_q <= '0;
      else if (sel_tick)  pcnt_q <= (pcnt_q == pdiv) ? '0 : pcnt_q + 1'b1;
   end

   generate
      if (HAS_MN) begin : g_mn
         logic [ACCW-1:0] acc_q;
         logic [ACCW-1:0] sum;
         logic            frac;
         logic            hit;

         assign frac = mn_on && (n_val != '0);
         assign sum  = acc_q + {1'b0, m_val};
         assign hit  = sum >= {1'b0, n_val};
         assign tick = frac ? (pre_tick && hit) : pre_tick;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                acc_q <= '0;
            else if (clr)              acc_q <= '0;
            else if (pre_tick && frac) acc_q <= hit ? sum - {1'b0, n_val} : sum;
         end
      end else begin : g_nomn
         logic unused_mn;
         assign unused_mn = ^{m_val, n_val, mn_on};
         assign tick      = pre_tick;
      end
   endgenerate
endmodule

// File: rtl/rcfg_handover.sv
module rcfg_handover (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_we,
   input  logic wr_sel,
   input  logic wr_en,
   input  logic tgt_tick,
   output logic active,
   output logic enable,
   output logic pending,
   output logic fire
);
   logic seen_q;

   assign fire = pending && enable && seen_q && tgt_tick && !ctrl_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         enable  <= 1'b0;
         pending <= 1'b0;
         seen_q  <= 1'b0;
      end else if (ctrl_we) begin
         enable <= wr_en;
         if (!wr_en || !enable) begin
            active  <= wr_sel;
            pending <= 1'b0;
            seen_q  <= 1'b0;
         end else if (wr_sel != active) begin
            if (!pending) seen_q <= 1'b0;
            pending <= 1'b1;
         end else begin
            pending <= 1'b0;
            seen_q  <= 1'b0;
         end
      end else if (pending && tgt_tick) begin
         if (seen_q) begin
            active  <= ~active;
            pending <= 1'b0;
            seen_q  <= 1'b0;
         end else begin
            seen_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dual_bank_clkcfg.sv
module dual_bank_clkcfg
   import rcfg_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int PDW    = 4,
   parameter int MNW    = 8,
   parameter int DW     = 32,
   parameter bit HAS_MN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_tick,
   input  logic            bus_we,
   input  logic [1:0]      bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic [1:0]      bus_raddr,
   output logic [DW-1:0]   bus_rdata,
   output logic            out_tick
);
   localparam int SRCW   = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int PD_LO  = SRCW;
   localparam int M_LO   = PD_LO + PDW;
   localparam int N_LO   = M_LO + MNW;
   localparam int MNE_B  = N_LO + MNW;
   localparam int CFG_W  = MNE_B + 1;

   generate
      if (DW < CFG_W || DW < 4) begin : g_bad_dw
         $error("DW too narrow for a bank word");
      end
      if (NSRC < 2 || NSRC != (1 << SRCW)) begin : g_bad_nsrc
         $error("NSRC must be a power of two, at least 2");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q [NBANK];
   logic [NBANK-1:0] bank_tick;
   logic [NBANK-1:0] bank_wr;
   logic [NBANK-1:0] bank_clr;
   logic             active_q, en_q, pend_q, fire;
   logic             err_q;
   logic             ctrl_we;
   logic             refused;
   logic             tgt_tick;
   logic [CFG_W-1:0] act_cfg;
   logic [CFG_W-1:0] idle_cfg;
   logic             unused_hi;

   assign ctrl_we   = bus_we && (bus_addr == RA_CTRL);
   assign act_cfg   = cfg_q[active_q];
   assign idle_cfg  = cfg_q[~active_q];
   assign tgt_tick  = src_tick[idle_cfg[SRCW-1:0]];
   assign unused_hi = ^bus_wdata;

   // write gating per bank
   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic hit;
         logic locked;
         assign hit         = bus_we && (bus_addr == 2'(b + 1));
         assign locked      = en_q && ((active_q == 1'(b)) || pend_q);
         assign bank_wr[b]  = hit && !locked;
         assign bank_clr[b] = bank_wr[b];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cfg_q[b] <= '0;
            else if (bank_wr[b]) cfg_q[b] <= bus_wdata[CFG_W-1:0];
         end

         rcfg_divider #(
            .NSRC(NSRC), .SRCW(SRCW), .PDW(PDW), .MNW(MNW), .HAS_MN(HAS_MN)
         ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (bank_clr[b]),
            .src_tick(src_tick),
            .src_sel (cfg_q[b][SRCW-1:0]),
            .pdiv    (cfg_q[b][PD_LO +: PDW]),
            .m_val   (cfg_q[b][M_LO +: MNW]),
            .n_val   (cfg_q[b][N_LO +: MNW]),
            .mn_on   (cfg_q[b][MNE_B]),
            .tick    (bank_tick[b])
         );
      end
   endgenerate

   assign refused = bus_we && ((bus_addr == RA_BANK0) || (bus_addr == RA_BANK1))
                    && !(|bank_wr);

   rcfg_handover u_hand (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we),
      .wr_sel  (bus_wdata[CB_ACTIVE]),
      .wr_en   (bus_wdata[CB_ENABLE]),
      .tgt_tick(tgt_tick),
      .active  (active_q),
      .enable  (en_q),
      .pending (pend_q),
      .fire    (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               err_q <= 1'b0;
      else if (refused)                         err_q <= 1'b1;
      else if (ctrl_we && bus_wdata[CB_ERROR])  err_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_tick <= 1'b0;
      else        out_tick <= en_q && !fire && bank_tick[active_q];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_raddr)
         RA_CTRL: begin
            bus_rdata[CB_ACTIVE]  = active_q;
            bus_rdata[CB_ENABLE]  = en_q;
            bus_rdata[CB_PENDING] = pend_q;
            bus_rdata[CB_ERROR]   = err_q;
         end
         RA_BANK0: bus_rdata[CFG_W-1:0] = cfg_q[0];
         RA_BANK1: bus_rdata[CFG_W-1:0] = cfg_q[1];
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dual_bank_clkcfg_chk.sv
module dual_bank_clkcfg_chk #(
   parameter int CFG_W = 23
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             active,
   input logic             pending,
   input logic             err,
   input logic             out_tick,
   input logic             we,
   input logic [1:0]       addr,
   input logic             wdata3,
   input logic [CFG_W-1:0] act_cfg
);
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !out_tick); // R2

   AST_SWITCH_VIA_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (active != $past(active))) |-> $past(pending)); // R8

   AST_PENDING_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> en); // R8

   AST_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (active != $past(active))) |-> !out_tick); // R9

   AST_LIVE_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (active == $past(active))) |-> $stable(act_cfg)); // R5

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err) && !($past(we) && ($past(addr) == 2'd0) && $past(wdata3))) |-> err); // R6
endmodule

bind dual_bank_clkcfg dual_bank_clkcfg_chk #(.CFG_W(CFG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en_q),
   .active  (active_q),
   .pending (pend_q),
   .err     (err_q),
   .out_tick(out_tick),
   .we      (bus_we),
   .addr    (bus_addr),
   .wdata3  (bus_wdata[3]),
   .act_cfg (act_cfg)
);

// File: tb/sim_dual_bank_clkcfg.sv
module sim_dual_bank_clkcfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  bus_raddr = '0;
   logic [31:0] bus_rdata;
   logic        out_tick;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_bank_clkcfg u0 (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
      .bus_rdata(bus_rdata), .out_tick(out_tick)
   );

   // reference state
   logic [22:0] m_cfg [2];
   logic [3:0]  m_pc  [2];
   logic [8:0]  m_acc [2];
   bit m_en, m_act, m_pend, m_seen, m_err, m_out;

   function automatic logic [31:0] mk(int s, int pd, int m, int n, int mne);
      logic [31:0] w = '0;
      w[1:0] = 2'(s); w[5:2] = 4'(pd); w[13:6] = 8'(m); w[21:14] = 8'(n); w[22] = 1'(mne);
      return w;
   endfunction

   function automatic logic [31:0] ctrl_exp();
      return {28'd0, m_err, m_pend, m_en, m_act};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_step(bit we, logic [1:0] a, logic [31:0] d, logic [3:0] s);
      bit st[2], pre[2], t[2], frac[2], acc_ok[2];
      logic [8:0] sum[2];
      bit ctrl = we && a == 2'd0;
      bit fire;
      bit wr_ok[2];
      for (int b = 0; b < 2; b++) begin
         st[b]   = s[m_cfg[b][1:0]];
         pre[b]  = st[b] && (m_pc[b] == m_cfg[b][5:2]);
         frac[b] = m_cfg[b][22] && (m_cfg[b][21:14] != 0);
         sum[b]  = m_acc[b] + {1'b0, m_cfg[b][13:6]};
         acc_ok[b] = sum[b] >= {1'b0, m_cfg[b][21:14]};
         t[b]    = frac[b] ? (pre[b] && acc_ok[b]) : pre[b];
         wr_ok[b] = we && (a == 2'(b + 1)) && !(m_en && ((m_act == 1'(b)) || m_pend));
      end
      fire  = m_pend && m_en && m_seen && s[m_cfg[~m_act][1:0]] && !ctrl;
      m_out = m_en && !fire && t[m_act];
      for (int b = 0; b < 2; b++) begin
         if (wr_ok[b]) begin
            m_cfg[b] = d[22:0]; m_pc[b] = 0; m_acc[b] = 0;
         end else begin
            if (st[b]) m_pc[b] = pre[b] ? 4'd0 : m_pc[b] + 4'd1;
            if (pre[b] && frac[b]) m_acc[b] = acc_ok[b] ? sum[b] - {1'b0, m_cfg[b][21:14]} : sum[b];
         end
      end
      if (we && (a == 2'd1 || a == 2'd2) && !wr_ok[0] && !wr_ok[1]) m_err = 1;
      else if (ctrl && d[3]) m_err = 0;
      if (ctrl) begin
         if (!d[1] || !m_en) begin m_act = d[0]; m_pend = 0; m_seen = 0; end
         else if (d[0] != m_act) begin if (!m_pend) m_seen = 0; m_pend = 1; end
         else begin m_pend = 0; m_seen = 0; end
         m_en = d[1];
      end else if (m_pend && s[m_cfg[~m_act][1:0]]) begin
         if (m_seen) begin m_act = ~m_act; m_pend = 0; m_seen = 0; end
         else m_seen = 1;
      end
   endtask

   int pulses;

   task automatic cyc(bit we, logic [1:0] a, logic [31:0] d, logic [3:0] s, string req);
      bus_we = we; bus_addr = a; bus_wdata = d; src_tick = s;
      model_step(we, a, d, s);
      @(posedge clk); #1;
      bus_we = 1'b0; src_tick = '0;
      chk(out_tick === m_out, req, 32'(out_tick), 32'(m_out));
      if (out_tick) pulses++;
   endtask

   task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
      bus_raddr = a; #0.5;
      chk(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int b = 0; b < 2; b++) begin m_cfg[b] = 0; m_pc[b] = 0; m_acc[b] = 0; end
      m_en = 0; m_act = 0; m_pend = 0; m_seen = 0; m_err = 0; m_out = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, 32'd0, "R1 ctrl");
      rd(2'd1, 32'd0, "R1 bank0");
      rd(2'd2, 32'd0, "R1 bank1");
      chk(out_tick === 1'b0, "R1 out", 32'(out_tick), 0);

      // R3 divide by 3 on source 0, disabled write accepted, then enable
      cyc(1, 2'd1, mk(0, 2, 0, 0, 0), 4'b0, "R10 cfg");
      cyc(1, 2'd0, 32'h2, 4'b0, "R10 en");
      rd(2'd0, 32'h2, "R10 live bank0 at once");
      pulses = 0;
      for (int i = 0; i < 30; i++) cyc(0, 0, 0, 4'b0001, "R3 cadence");
      chk(pulses == 10, "R3 pulse count", 32'(pulses), 10);

      // R5 refused write to live bank
      cyc(1, 2'd1, mk(1, 0, 0, 0, 0), 4'b0001, "R5 refused");
      rd(2'd1, mk(0, 2, 0, 0, 0), "R5 live word kept");
      rd(2'd0, 32'hA, "R5 err set");
      cyc(0, 0, 0, 4'b0, "R6 idle");
      rd(2'd0, 32'hA, "R6 err sticky");
      cyc(1, 2'd0, 32'hA, 4'b0, "R6 clear");
      rd(2'd0, 32'h2, "R6 err cleared");

      // R4 idle bank: source 1, M/N 3/8
      cyc(1, 2'd2, mk(1, 0, 3, 8, 1), 4'b0, "R5 idle write");
      rd(2'd2, mk(1, 0, 3, 8, 1), "R5 idle accepted");
      rd(2'd0, 32'h2, "R5 no err");
      // R8 request, silent target source
      cyc(1, 2'd0, 32'h3, 4'b0, "R8 request");
      rd(2'd0, 32'h6, "R7 old bank while pending");
      for (int i = 0; i < 20; i++) cyc(0, 0, 0, 4'b0001, "R9 old bank drives");
      rd(2'd0, 32'h6, "R8 stalled without source");
      cyc(1, 2'd2, mk(2, 0, 0, 0, 0), 4'b0001, "R5 pending lock");
      rd(2'd0, 32'hE, "R5 err on pending write");
      cyc(1, 2'd0, 32'hB, 4'b0, "R6 clear keep pending");
      cyc(0, 0, 0, 4'b0010, "R8 first target strobe");
      rd(2'd0, 32'h6, "R8 one strobe not enough");
      cyc(0, 0, 0, 4'b0011, "R9 switch cycle gated");
      chk(out_tick === 1'b0, "R9 no pulse on switch", 32'(out_tick), 0);
      rd(2'd0, 32'h3, "R8 switched on second strobe");
      pulses = 0;
      for (int i = 0; i < 32; i++) cyc(0, 0, 0, 4'b0010, "R4 fractional");
      chk(pulses == 12, "R4 3 of 8", 32'(pulses), 12);

      // R8 cancel
      cyc(1, 2'd0, 32'h2, 4'b0, "R8 request back");
      cyc(1, 2'd0, 32'h3, 4'b0, "R8 cancel");
      rd(2'd0, 32'h3, "R8 cancelled");

      // R10 disable then rewrite live bank directly
      cyc(1, 2'd0, 32'h1, 4'b0, "R10 disable");
      cyc(1, 2'd2, mk(3, 1, 0, 0, 0), 4'b0, "R10 direct write");
      rd(2'd2, mk(3, 1, 0, 0, 0), "R10 live rewritten");
      rd(2'd0, 32'h1, "R10 no err");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [3:0]  s = 4'($urandom);
         bit          we = ($urandom % 12) == 0;
         logic [1:0]  a = 2'($urandom % 3);
         logic [31:0] d;
         if (a == 0) d = {28'd0, 1'($urandom % 8 == 0), 1'b0, 1'($urandom % 8 != 0), 1'($urandom)};
         else begin
            int n = $urandom % 16;
            int m = (n == 0) ? 0 : $urandom % (n + 1);
            d = mk($urandom % 4, $urandom % 4, m, n, $urandom % 2);
         end
         cyc(we, a, d, s, "R2 random cadence");
         rd(2'd0, ctrl_exp(), "R7 random ctrl");
         rd(2'd1, {9'd0, m_cfg[0]}, "R5 random bank0");
         rd(2'd2, {9'd0, m_cfg[1]}, "R5 random bank1");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule